// File: doc/BRIEF.md
# Glitch-Free Double-Data-Rate Pad Driver

This block drives each output pin twice per clock cycle, using only ordinary flip-flops and one two-input XOR per pin. At every rising clock edge it takes a two-bit word for each pin and an enable. The upper bit of the pair is presented on the pin while the clock is high. The lower bit is presented while the clock is low. The clock never reaches the output as a data or select signal.

Each pin has three flip-flops. Two of them, the rising flop and the pending flop, load on the rising edge. The falling flop loads on the falling edge and only copies the pending flop. The pin is the XOR of the rising flop and the falling flop. Both next values are worked out together at the rising edge, so in each half-cycle exactly one of the two XOR inputs changes. When the enable is low, the pin holds the upper bit for the whole cycle. The state still follows the current pending value, so the pin does not jump when the enable changes.

The number of pins is set by a parameter. Each pin is fully independent of the others.

Top module: `ddrx_out`

## Requirements
- R1: While `rst_n` is low, every flip-flop is cleared to zero and every bit of `pad` is 0.
- R2: With `en` high at a rising edge, pin i shows `word[2i+1]` (the upper bit) for the whole high half that follows that edge.
- R3: With `en` high at a rising edge, pin i shows `word[2i]` (the lower bit) for the whole low half that follows that edge.
- R4: The falling flop only copies the pending flop at each falling edge, so `pad` changes only just after a clock edge and stays steady inside each half.
- R5: While enabled, the rising flop loads upper XOR pending, and the pending flop loads lower XOR upper XOR its previous value. The pending flop therefore toggles exactly when the two bits of the word differ.
- R6: With `en` low at a rising edge, pin i shows `word[2i+1]` in both halves of the following cycle.
- R7: While disabled, the pending flop keeps its value and the rising flop loads upper XOR pending. The resulting pattern of {rising, pending} is 01/10 for upper=1 (pending 1/0) and 11/00 for upper=0 (pending 1/0). Runs of disabled cycles of any length therefore hand over cleanly to enabled data.
- R8: The pins are independent. A change in one pin's pair never alters another pin's output.
- R9: Changing the enable in either direction between consecutive cycles loses no half-cycle. The first cycle after the change already follows R2/R3 or R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising and falling edges both used |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Double-rate enable, sampled at the rising edge |
| word | input | 2*WIDTH | Bit pair per pin: bit 2i+1 is the upper (high-half) bit and bit 2i is the lower (low-half) bit of pin i |
| pad | output | WIDTH | Pin outputs |

## Verification
The bench builds the block with WIDTH=3. Three pins are enough to give each pin different upper and lower bits within the same cycle, so crossed wiring between pins or between the two halves shows up as a wrong bit. The stimulus keeps the enable low over several cycles while the upper bits change, and toggles it in both directions. This sets up every combination of upper bit and pending state that a disabled load can meet. The pin is sampled twice within one half-cycle to show it is steady there.

// File: rtl/ddrx_pkg.sv
`timescale 1ns/1ps
package ddrx_pkg;

  // State loaded at each rising edge for one pin.
  typedef struct packed {
    logic rise_bit;   // rising-edge flop, one XOR input
    logic pend_bit;   // value the falling flop will copy next
  } rise_state_t;

  // Next rising-edge state of one pin.
  function automatic rise_state_t rise_next(input logic en,
                                            input logic hi,
                                            input logic lo,
                                            input logic pend);
    rise_state_t nxt;
    if (en) begin
      nxt.rise_bit = hi ^ pend;
      nxt.pend_bit = lo ^ hi ^ pend;
    end else begin
      unique case ({hi, pend})
        2'b11:   nxt = '{rise_bit: 1'b0, pend_bit: 1'b1};
        2'b10:   nxt = '{rise_bit: 1'b1, pend_bit: 1'b0};
        2'b01:   nxt = '{rise_bit: 1'b1, pend_bit: 1'b1};
        default: nxt = '{rise_bit: 1'b0, pend_bit: 1'b0};
      endcase
    end
    return nxt;
  endfunction

  // Pin value from the two flops that feed the XOR.
  function automatic logic pad_of(input logic rise_q, input logic fall_q);
    return rise_q ^ fall_q;
  endfunction

endpackage

// File: rtl/ddrx_rise_stage.sv
`timescale 1ns/1ps
module ddrx_rise_stage
  import ddrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hi,
  input  logic lo,
  output logic rise_q,
  output logic pend_q
);

  rise_state_t state_q;
  rise_state_t state_d;

  always_comb state_d = rise_next(en, hi, lo, state_q.pend_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign rise_q = state_q.rise_bit;
  assign pend_q = state_q.pend_bit;

  // Named events for the checks below.
  wire word_differs = en && (hi != lo);
  wire word_same_en = en && (hi == lo);

  assert_pend_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_differs |=> (pend_q != $past(pend_q)));

  assert_pend_keep_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_same_en |=> (pend_q == $past(pend_q)));

  assert_pend_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(pend_q));

  assert_off_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && hi) |=> (rise_q != pend_q));

endmodule

// File: rtl/ddrx_fall_stage.sv
`timescale 1ns/1ps
module ddrx_fall_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_in,
  output logic fall_q
);

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= 1'b0;
    else        fall_q <= pend_in;
  end

  // Just before each rising edge, the falling flop holds the pending value.
  assert_fall_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q == pend_in);

endmodule

// File: rtl/ddrx_lane.sv
`timescale 1ns/1ps
module ddrx_lane
  import ddrx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hi,
  input  logic lo,
  output logic pad
);

  logic rise_q;
  logic pend_q;
  logic fall_q;

  ddrx_rise_stage u_rise (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .hi     (hi),
    .lo     (lo),
    .rise_q (rise_q),
    .pend_q (pend_q)
  );

  ddrx_fall_stage u_fall (
    .clk     (clk),
    .rst_n   (rst_n),
    .pend_in (pend_q),
    .fall_q  (fall_q)
  );

  wire lane_pad = pad_of(rise_q, fall_q);
  assign pad = lane_pad;

  // Shadow of the pair the pin should show, kept only for the checks.
  logic shadow_hi;
  logic shadow_lo;
  logic shadow_off;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_hi  <= 1'b0;
      shadow_lo  <= 1'b0;
      shadow_off <= 1'b0;
    end else begin
      shadow_hi  <= hi;
      shadow_lo  <= en ? lo : hi;
      shadow_off <= !en;
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk)
    !rst_n |-> (lane_pad == 1'b0));

  // At a falling edge, the sampled pin value is the one from the high half.
  assert_pad_high_R2: assert property (@(negedge clk) disable iff (!rst_n)
    lane_pad == shadow_hi);

  // At a rising edge, the sampled pin value is the one from the low half.
  assert_pad_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_pad == shadow_lo);

  assert_hold_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    shadow_off |-> (lane_pad == shadow_hi));

endmodule

// File: rtl/ddrx_out.sv
`timescale 1ns/1ps
module ddrx_out #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [2*WIDTH-1:0] word,
  output logic [WIDTH-1:0]   pad
);

  localparam int PAIR_W = 2 * WIDTH;

  logic [PAIR_W-1:0] word_w;
  assign word_w = word;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    ddrx_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .hi    (word_w[2*i+1]),
      .lo    (word_w[2*i]),
      .pad   (pad[i])
    );
  end

endmodule

// File: tb/tb_ddrx_out.sv
`timescale 1ns/1ps
module tb_ddrx_out;

  localparam int W  = 3;
  localparam int DW = 2 * W;
  localparam int NV = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [DW-1:0] word = '0;
  logic [W-1:0]  pad;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ddrx_out #(.WIDTH(W)) dut (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .word  (word),
    .pad   (pad)
  );

  // {en, word, expected high half, expected low half}
  typedef struct packed {
    logic          en;
    logic [DW-1:0] word;
    logic [W-1:0]  exp_hi;
    logic [W-1:0]  exp_lo;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 6'b101101, 3'b110, 3'b011},
    '{1'b1, 6'b010010, 3'b001, 3'b100},
    '{1'b1, 6'b111111, 3'b111, 3'b111},
    '{1'b1, 6'b000000, 3'b000, 3'b000},
    '{1'b1, 6'b100110, 3'b101, 3'b010},
    '{1'b0, 6'b101010, 3'b111, 3'b111},
    '{1'b0, 6'b010101, 3'b000, 3'b000},
    '{1'b0, 6'b111000, 3'b110, 3'b110},
    '{1'b0, 6'b001110, 3'b011, 3'b011},
    '{1'b1, 6'b011001, 3'b010, 3'b101},
    '{1'b0, 6'b100001, 3'b100, 3'b100},
    '{1'b1, 6'b110011, 3'b101, 3'b101},
    '{1'b1, 6'b011110, 3'b011, 3'b110},
    '{1'b0, 6'b000011, 3'b001, 3'b001}
  };

  task automatic check(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pad=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one word, then sample the middle of the high and low halves.
  task automatic cycle(input logic e, input logic [DW-1:0] w,
                       input logic [W-1:0] eh, input logic [W-1:0] el,
                       input string rh, input string rl);
    en = e;
    word = w;
    @(posedge clk); #1.25;
    check(rh, pad, eh);
    @(negedge clk); #1.25;
    check(rl, pad, el);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: timeout actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1.25 check("R1 reset high half", pad, '0);
    @(negedge clk); #1.25;
    check("R1 reset low half", pad, '0);
    rst_n = 1'b1;

    // first cycle after reset is not checked
    en = 1'b1; word = '0;
    @(posedge clk); @(negedge clk); #1.25;

    // Table walk: R2/R3 enabled, R6/R7 disabled runs, R9 enable changes
    for (int k = 0; k < NV; k++) begin
      if (VECS[k].en)
        cycle(VECS[k].en, VECS[k].word, VECS[k].exp_hi, VECS[k].exp_lo,
              "R2/R5/R9 high half", "R3/R5/R9 low half");
      else
        cycle(VECS[k].en, VECS[k].word, VECS[k].exp_hi, VECS[k].exp_lo,
              "R6/R7/R9 high half", "R6/R7/R9 low half");
    end

    // R8: only pin 1 moves, pins 0 and 2 hold distinct pairs
    cycle(1'b1, 6'b100001, 3'b100, 3'b001, "R8 high", "R8 low");
    cycle(1'b1, 6'b101001, 3'b110, 3'b001, "R8 high", "R8 low");
    cycle(1'b1, 6'b100101, 3'b100, 3'b011, "R8 high", "R8 low");

    // R4: the pin stays steady inside each half
    en = 1'b1; word = 6'b011001;
    @(posedge clk); #0.5;
    check("R4 early high", pad, 3'b010);
    #1.5 check("R4 late high", pad, 3'b010);
    @(negedge clk); #0.5;
    check("R4 early low", pad, 3'b101);
    #1.5 check("R4 late low", pad, 3'b101);

    // R7: a long disabled run with the upper bits changing, then enabled
    for (int k = 0; k < 5; k++) begin
      logic [DW-1:0] w = DW'(k * 11 + 3);
      logic [W-1:0] h = {w[5], w[3], w[1]};
      cycle(1'b0, w, h, h, "R7 long hold high", "R7 long hold low");
    end
    cycle(1'b1, 6'b010110, 3'b001, 3'b110, "R9 resume high", "R9 resume low");

    // R1: asynchronous reset in the middle of a run
    en = 1'b1; word = 6'b111111;
    @(posedge clk); #1.0;
    rst_n = 1'b0;
    #0.5 check("R1 async reset", pad, '0);
    @(negedge clk); #1.25;
    check("R1 held in reset", pad, '0);
    rst_n = 1'b1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule